// File: doc/BRIEF.md
# Multi-Channel External Interrupt Aggregator

This block gathers up to 32 external interrupt request lines into one interrupt line for the processor. Every line passes through a synchroniser. A rising edge on a line whose enable bit is set records a pending request for that channel. While any request is pending, the block picks the channel with the lowest index, freezes that index in the source register, and holds the processor interrupt high until software acknowledges it.

Software uses a small memory-mapped port with three registers. The enable mask is at offset 0x0. The pending set is at offset 0x4. Bits of the pending set are cleared by writing zeros over them, and written ones leave them unchanged. The source index is at offset 0x8. Any write to the source register is the acknowledge. The channel count is fixed at build time. Software can find it by writing all ones to the enable mask and reading the mask back.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable, pending and source registers read 0x0, `cpu_irq_o` is low and `reg_ack_o` is low.
- R2: The enable register at offset 0x0 stores bit i only for channels i < NUM_CH. Writing 0xFFFFFFFF with NUM_CH=20 reads back 0x000FFFFF.
- R3: A 0-to-1 transition on `ext_irq_i[i]` of an enabled channel sets pending bit i on the third rising clock edge after the input change. A line held high sets the bit only once.
- R4: Transitions on a channel whose enable bit is clear, or on an unimplemented channel, never set a pending bit.
- R5: A write to the pending register at offset 0x4 clears each pending bit whose data bit is 0 and keeps each bit whose data bit is 1.
- R6: When a new edge and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R7: The source register at offset 0x8 returns, in bits 4:0, the index of the lowest-numbered pending channel, captured when the interrupt is raised. Channel 0 has the highest priority.
- R8: `cpu_irq_o` rises one cycle after the pending set becomes non-zero, only while a request is pending. The source index stays frozen while `cpu_irq_o` is high, even if a higher-priority request arrives.
- R9: A write to offset 0x8 while `cpu_irq_o` is high drops `cpu_irq_o` on the next edge. The line stays low for at least one cycle and then rises again with a new source index if requests remain.
- R10: Every strobe gets `reg_ack_o` high for exactly one cycle on the next edge, with read data valid in that cycle. Reads of unmapped offsets return 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 32 | Asynchronous external request lines |
| reg_stb_i | input | 1 | Single-cycle register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with `reg_ack_o` |
| reg_ack_o | output | 1 | Access response, one cycle after the strobe |
| cpu_irq_o | output | 1 | Interrupt to the processor |

## Verification
The hardest case to reach is an edge and a clearing write landing on the same pending bit in the same cycle. The input edge has to pass through the synchroniser first, so the write strobe must be placed exactly two edges after the input change. The bench sets the input on a falling edge, waits one more falling edge, and then issues the write so that the strobe is sampled on the same edge where the detected rise is sampled. A second hard case is a higher-priority request arriving while the interrupt is already held. The bench reaches it by raising channel 4 during service of channel 5 and checking that the source stays frozen until the acknowledge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned CH_MAX = 32;
   localparam int unsigned IDX_W  = 5;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFS_EN   = 4'h0;
   localparam logic [ADDR_W-1:0] OFS_PEND = 4'h4;
   localparam logic [ADDR_W-1:0] OFS_SRC  = 4'h8;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } irq_st_e;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_CH      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_MAX-1:0] raw_i,
   output logic [CH_MAX-1:0] rise_o
);
   // One extra flop past the synchroniser holds the previous level for edge detection.
   for (genvar i = 0; i < CH_MAX; i++) begin : g_ch
      if (i < NUM_CH) begin : g_impl
         logic [SYNC_STAGES:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-1:0], raw_i[i]};
         end
         assign rise_o[i] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
      end else begin : g_absent
         assign rise_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend
   import irq_agg_pkg::*;
#(
   parameter logic [CH_MAX-1:0] CH_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_MAX-1:0] rise_i,
   input  logic [CH_MAX-1:0] en_i,
   input  logic              clr_we_i,
   input  logic [CH_MAX-1:0] clr_keep_i,
   output logic [CH_MAX-1:0] pend_o
);
   logic [CH_MAX-1:0] pend_q;
   logic [CH_MAX-1:0] kept;

   // Zero data bits clear; a new edge is ORed in afterwards, so it wins a same-cycle clear.
   assign kept = clr_we_i ? (pend_q & clr_keep_i) : pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (kept | (rise_i & en_i)) & CH_MASK;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio
   import irq_agg_pkg::*;
(
   input  logic [CH_MAX-1:0] pend_i,
   output logic              any_o,
   output logic [IDX_W-1:0]  idx_o
);
   // Scan from the top down so the lowest set index is the one left in idx_o.
   always_comb begin
      idx_o = '0;
      for (int i = CH_MAX - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |pend_i;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_CH      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_MAX-1:0] ext_irq_i,
   input  logic              reg_stb_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              reg_ack_o,
   output logic              cpu_irq_o
);
   localparam logic [63:0]       MASK64  = (64'h1 << NUM_CH) - 64'h1;
   localparam logic [CH_MAX-1:0] CH_MASK = MASK64[CH_MAX-1:0];

   if (NUM_CH > CH_MAX) begin : g_bad_ch
      $error("irq_aggregator: NUM_CH must not exceed 32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_aggregator: SYNC_STAGES must be at least 2");
   end

   logic [CH_MAX-1:0] en_q;
   logic [CH_MAX-1:0] rise_w;
   logic [CH_MAX-1:0] pend_w;
   logic              any_w;
   logic [IDX_W-1:0]  idx_w;
   logic [IDX_W-1:0]  src_q;
   irq_st_e           st_q;

   logic wr_en, wr_pend, wr_src;
   assign wr_en   = reg_stb_i &  reg_we_i & (reg_addr_i == OFS_EN);
   assign wr_pend = reg_stb_i &  reg_we_i & (reg_addr_i == OFS_PEND);
   assign wr_src  = reg_stb_i &  reg_we_i & (reg_addr_i == OFS_SRC);

   irq_agg_sync #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (ext_irq_i),
      .rise_o (rise_w)
   );

   irq_agg_pend #(.CH_MASK(CH_MASK)) pend_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (rise_w),
      .en_i       (en_q),
      .clr_we_i   (wr_pend),
      .clr_keep_i (reg_wdata_i),
      .pend_o     (pend_w)
   );

   irq_agg_prio prio_i (
      .pend_i (pend_w),
      .any_o  (any_w),
      .idx_o  (idx_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= reg_wdata_i & CH_MASK;
   end

   // Service handshake: capture the winner, hold until software writes the source register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         src_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (any_w) begin
               src_q <= idx_w;
               st_q  <= ST_BUSY;
            end
            ST_BUSY: if (wr_src) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_irq_o = (st_q == ST_BUSY);

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      unique case (reg_addr_i)
         OFS_EN:   rd_mux = en_q;
         OFS_PEND: rd_mux = pend_w;
         OFS_SRC:  rd_mux = {{(DATA_W-IDX_W){1'b0}}, src_q};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_ack_o   <= 1'b0;
         reg_rdata_o <= '0;
      end else begin
         reg_ack_o   <= reg_stb_i;
         reg_rdata_o <= (reg_stb_i && !reg_we_i) ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_CH = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_stb_i,
   input logic              reg_we_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              reg_ack_o,
   input logic              cpu_irq_o,
   input logic [CH_MAX-1:0] en_q,
   input logic [CH_MAX-1:0] pend_w,
   input logic [IDX_W-1:0]  src_q
);
   localparam logic [63:0]       MASK64  = (64'h1 << NUM_CH) - 64'h1;
   localparam logic [CH_MAX-1:0] CH_MASK = MASK64[CH_MAX-1:0];

   a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      reg_stb_i |=> reg_ack_o);

   a_r10_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_stb_i |=> !reg_ack_o);

   a_r2_enable_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_stb_i && !reg_we_i && reg_addr_i == OFS_EN) |=> ((reg_rdata_o & ~CH_MASK) == '0));

   a_r4_disabled_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_w & ~$past(pend_w) & ~$past(en_q)) == '0));

   a_r8_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq_o && $past(cpu_irq_o)) |-> $stable(src_q));

   a_r8_raise_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq_o) |-> $past(pend_w != '0));

   a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq_o && reg_stb_i && reg_we_i && reg_addr_i == OFS_SRC) |=> !cpu_irq_o);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_stb_i   (reg_stb_i),
   .reg_we_i    (reg_we_i),
   .reg_addr_i  (reg_addr_i),
   .reg_rdata_o (reg_rdata_o),
   .reg_ack_o   (reg_ack_o),
   .cpu_irq_o   (cpu_irq_o),
   .en_q        (en_q),
   .pend_w      (pend_w),
   .src_q       (src_q)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
   import irq_agg_pkg::*;

   localparam int unsigned NCH = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CH_MAX-1:0] ext_irq = '0;
   logic              stb = 1'b0;
   logic              we = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              ack;
   logic              irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   always #10 clk = ~clk;

   irq_aggregator #(.NUM_CH(NCH)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_irq_i   (ext_irq),
      .reg_stb_i   (stb),
      .reg_we_i    (we),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .reg_ack_o   (ack),
      .cpu_irq_o   (irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // Monitor: every response is compared with the oldest expected read.
   always @(negedge clk) begin
      if (ack && exp_q.size() > 0) begin
         logic [31:0] e;
         string       t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(rdata === e, t, rdata, e);
      end
   end

   task automatic bus_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      stb = 1'b1; we = 1'b0; addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      stb = 1'b0;
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      stb = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      stb = 1'b0; we = 1'b0;
      chk(ack === 1'b1, "R10 ack after write", 32'(ack), 32'h1);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(irq === 1'b0, "R1 irq low after reset", 32'(irq), 32'h0);
      chk(ack === 1'b0, "R1 ack low after reset", 32'(ack), 32'h0);
      bus_rd(OFS_EN,   32'h0, "R1 enable reset");
      bus_rd(OFS_PEND, 32'h0, "R1 pending reset");
      bus_rd(OFS_SRC,  32'h0, "R1 source reset");
      @(negedge clk);
      chk(ack === 1'b0, "R10 ack lasts one cycle", 32'(ack), 32'h0);

      // R2: probe implemented channels
      bus_wr(OFS_EN, 32'hFFFF_FFFF);
      bus_rd(OFS_EN, 32'h000F_FFFF, "R2 implemented mask");

      // R4: disabled and unimplemented channels ignored
      bus_wr(OFS_EN, 32'h0000_00F0);
      ext_irq[2] = 1'b1; ext_irq[25] = 1'b1;
      idle(6);
      ext_irq[2] = 1'b0;
      bus_rd(OFS_PEND, 32'h0, "R4 disabled edge ignored");
      chk(irq === 1'b0, "R4 irq stays low", 32'(irq), 32'h0);

      // R3 / R8 / R7: edge on enabled channel 5, exact latency
      @(negedge clk);
      ext_irq[5] = 1'b1;
      idle(2);
      chk(irq === 1'b0, "R3 not yet pending after two edges", 32'(irq), 32'h0);
      @(negedge clk);
      chk(irq === 1'b0, "R8 irq one cycle after pending", 32'(irq), 32'h0);
      @(negedge clk);
      chk(irq === 1'b1, "R8 irq raised", 32'(irq), 32'h1);
      bus_rd(OFS_PEND, 32'h0000_0020, "R3 pending ch5");
      bus_rd(OFS_SRC,  32'd5, "R7 source ch5");

      // R8: higher-priority arrival does not move the frozen source
      ext_irq[4] = 1'b1;
      idle(5);
      bus_rd(OFS_PEND, 32'h0000_0030, "R3 pending ch4 and ch5");
      bus_rd(OFS_SRC,  32'd5, "R8 source frozen");

      // R5: clear ch5 only; held level of ch5 does not re-set it (R3)
      bus_wr(OFS_PEND, 32'hFFFF_FFDF);
      idle(3);
      bus_rd(OFS_PEND, 32'h0000_0010, "R5 clear keeps ones");

      // R9: acknowledge, gap, re-raise for ch4
      bus_wr(OFS_SRC, 32'h0);
      chk(irq === 1'b0, "R9 irq drops after ack", 32'(irq), 32'h0);
      @(negedge clk);
      chk(irq === 1'b1, "R9 irq re-raised", 32'(irq), 32'h1);
      bus_rd(OFS_SRC, 32'd4, "R9 next source ch4");

      // R5: all-ones write keeps, zero write clears
      bus_wr(OFS_PEND, 32'hFFFF_FFFF);
      bus_rd(OFS_PEND, 32'h0000_0010, "R5 all ones keeps");
      bus_wr(OFS_PEND, 32'h0);
      bus_wr(OFS_SRC, 32'h0);
      bus_rd(OFS_PEND, 32'h0, "R5 zero clears");
      idle(2);
      chk(irq === 1'b0, "R9 stays low with nothing pending", 32'(irq), 32'h0);

      // R6: edge on ch6 and clearing write reach the bit in the same cycle
      @(negedge clk);
      ext_irq[6] = 1'b1;
      @(negedge clk);
      bus_wr(OFS_PEND, 32'h0);
      bus_rd(OFS_PEND, 32'h0000_0040, "R6 edge wins over clear");
      bus_wr(OFS_PEND, 32'h0);
      bus_wr(OFS_SRC, 32'h0);

      // R7: channels 0 and 19 together, 0 wins
      bus_wr(OFS_EN, 32'h0008_0001);
      @(negedge clk);
      ext_irq[0] = 1'b1; ext_irq[19] = 1'b1;
      idle(6);
      bus_rd(OFS_PEND, 32'h0008_0001, "R3 pending ch0 and ch19");
      bus_rd(OFS_SRC,  32'd0, "R7 lowest index wins");
      bus_wr(OFS_PEND, 32'hFFFF_FFFE);
      bus_wr(OFS_SRC, 32'h0);
      @(negedge clk);
      bus_rd(OFS_SRC,  32'd19, "R7 next source ch19");

      // R10: unmapped offset
      bus_wr(4'hC, 32'hFFFF_FFFF);
      bus_rd(4'hC, 32'h0, "R10 unmapped reads zero");
      bus_rd(OFS_EN, 32'h0008_0001, "R10 unmapped write no effect");

      idle(3);
      chk(exp_q.size() == 0, "R10 every read answered", exp_q.size(), 32'h0);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R10 actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule